// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block turns a master audio clock into the two timing signals of a serial audio link. The first is a bit clock at one half or one quarter of the master rate. The second is a left/right frame clock that runs at a fixed number of bit-clock periods and has a 50% duty cycle. A single 32-bit configuration word controls the block. Its fields set the run/stop state, the bit-clock ratio, the frame ratio, the bit-clock edge on which the frame clock moves, and an override flag. The override flag tells the attached audio interface to use these settings instead of its own clock configuration.

All logic runs in the master clock domain. Both outputs are registers clocked by the master clock. The bit-clock divider emits one-cycle strobes at its rising and falling transitions. The frame divider counts the strobes of the selected polarity, so the frame clock changes in the same master cycle as the chosen bit-clock edge. When the block is stopped, both outputs are held low and both counters are cleared. A restart therefore always begins from the same phase.

Top module: `audio_clk_gen`

## Requirements
- R1: With bit 16 clear, bclk_o toggles on every master clock edge (divide by 2). With bit 16 set, it toggles every second master clock edge (divide by 4). Every high and low phase lasts the same number of master cycles.
- R2: The field at bits 18:17 sets the frame ratio in bit-clock periods: code 0 gives 32, code 1 gives 64, code 2 gives 128.
- R3: Code 3 in bits 18:17 is invalid. While it is selected, lrclk_o stays low and bclk_o keeps running.
- R4: lrclk_o is high for exactly half of each frame and low for the other half.
- R5: With bit 19 clear, lrclk_o changes only in the master cycle in which bclk_o goes from 0 to 1. With bit 19 set, it changes only in the cycle in which bclk_o goes from 1 to 0.
- R6: While bit 31 is clear, bclk_o and lrclk_o are both low from the first master edge after the bit is cleared.
- R7: After bit 31 is set, bclk_o first rises after N/2 master edges, where N is the bit-clock ratio. lrclk_o first rises on the F/2-th bit-clock edge of the selected polarity, where F is the frame ratio.
- R8: cfg_override_o equals bit 29 of the configuration word one master edge later, whatever the state of bit 31.
- R9: While rst_n is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Configuration word: 31 run, 29 override, 19 polarity, 18:17 frame ratio, 16 bit-clock ratio |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Left/right frame clock |
| cfg_override_o | output | 1 | Registered override flag for the audio interface |

## Verification
The bench uses the default parameters: bit-clock ratios of 2 and 4, a base frame ratio of 32, and three valid ratio codes. This puts every valid code and the invalid code 3 within reach. The longest frame is 512 master cycles, so several full frames fit in each run. A table of seven configurations covers both bit-clock ratios, every frame ratio, both polarities and the override bit. For each configuration the bench measures the length of every bit-clock and frame-clock phase and checks the first rise of each output against the restart timing. Directed cases then cover stopping in mid-frame, the override bit with the run bit clear, and reset asserted while the clocks are running.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Field positions are decoded by the audio interface next to this block.
    localparam int RUN_BIT   = 31;
    localparam int OVR_BIT   = 29;
    localparam int POL_BIT   = 19;
    localparam int FRM_LSB   = 17;
    localparam int FRM_W     = 2;
    localparam int BRAT_BIT  = 16;

    typedef struct packed {
        logic             run;
        logic             ovr;
        logic             pol;
        logic [FRM_W-1:0] frm;
        logic             slow;
    } acfg_t;

endpackage

// File: rtl/audclk_bit_div.sv
module audclk_bit_div #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic slow_i,
    output logic bclk_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int SLOW_HALF = SLOW_DIV / 2;
    localparam int CW        = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV / 2 - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } st_t;

    st_t           s_d, s_q;
    logic          tick;
    logic [CW-1:0] lim;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        lim  = slow_i ? LIM_SLOW : LIM_FAST;
        if (!en_i) begin
            s_d = '0;
        end else if (s_q.cnt >= lim) begin
            tick       = 1'b1;
            s_d.cnt    = '0;
            s_d.bclk   = ~s_q.bclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk_o = s_q.bclk;
    assign rise_o = tick & ~s_q.bclk;
    assign fall_o = tick & s_q.bclk;

    // R6
    bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !bclk_o);

    // R1
    bclk_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !slow_i) |=> (bclk_o != $past(bclk_o)));

endmodule

// File: rtl/audclk_frame_div.sv
module audclk_frame_div #(
    parameter int BASE_RATIO = 32,
    parameter int NUM_RATIOS = 3,
    parameter int CODE_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              pol_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              lrclk_o
);

    localparam int BASE_HALF = BASE_RATIO / 2;
    localparam int MAX_HALF  = BASE_HALF << (NUM_RATIOS - 1);
    localparam int CW        = $clog2(MAX_HALF + 1);
    localparam logic [CW-1:0]   BH    = CW'(BASE_HALF);
    localparam logic [CODE_W:0] NUM_R = (CODE_W + 1)'(NUM_RATIOS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lr;
    } st_t;

    st_t           s_d, s_q;
    logic          code_ok;
    logic          edge_ev;
    logic [CW-1:0] lim;

    always_comb begin
        s_d     = s_q;
        code_ok = ({1'b0, code_i} < NUM_R);
        edge_ev = pol_i ? fall_i : rise_i;
        lim     = (BH << code_i) - 1'b1;
        if (!en_i || !code_ok) begin
            s_d = '0;
        end else if (edge_ev) begin
            if (s_q.cnt >= lim) begin
                s_d.cnt = '0;
                s_d.lr  = ~s_q.lr;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lrclk_o = s_q.lr;

    // R3
    lr_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok |=> !lrclk_o);

    // R6
    lr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !lrclk_o);

    // R5
    lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && code_ok && !(pol_i ? fall_i : rise_i)) |=> $stable(lrclk_o));

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen #(
    parameter int FAST_DIV   = 2,
    parameter int SLOW_DIV   = 4,
    parameter int BASE_RATIO = 32,
    parameter int NUM_RATIOS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_i,
    output logic        bclk_o,
    output logic        lrclk_o,
    output logic        cfg_override_o
);
    import audclk_pkg::*;

    typedef struct packed {
        logic ovr;
    } top_st_t;

    acfg_t   cfg;
    top_st_t t_d, t_q;
    logic    rise_w, fall_w;
    logic    code_ok;
    logic    unused_cfg;

    always_comb begin
        cfg.run  = cfg_i[RUN_BIT];
        cfg.ovr  = cfg_i[OVR_BIT];
        cfg.pol  = cfg_i[POL_BIT];
        cfg.frm  = cfg_i[FRM_LSB +: FRM_W];
        cfg.slow = cfg_i[BRAT_BIT];
        code_ok  = (int'(cfg.frm) < NUM_RATIOS);
        t_d      = t_q;
        t_d.ovr  = cfg.ovr;
    end

    assign unused_cfg = ^{cfg_i[30], cfg_i[28:20], cfg_i[15:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cfg_override_o = t_q.ovr;

    audclk_bit_div #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_bit_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cfg.run),
        .slow_i (cfg.slow),
        .bclk_o (bclk_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    audclk_frame_div #(
        .BASE_RATIO (BASE_RATIO),
        .NUM_RATIOS (NUM_RATIOS),
        .CODE_W     (FRM_W)
    ) u_frame_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cfg.run),
        .code_i  (cfg.frm),
        .pol_i   (cfg.pol),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .lrclk_o (lrclk_o)
    );

    // R5
    lr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg.run) && $past(code_ok) && !$past(cfg.pol)
         && (lrclk_o != $past(lrclk_o))) |-> (bclk_o && !$past(bclk_o)));

    // R5
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg.run) && $past(code_ok) && $past(cfg.pol)
         && (lrclk_o != $past(lrclk_o))) |-> (!bclk_o && $past(bclk_o)));

endmodule

// File: tb/audio_clk_gen_tb.sv
module audio_clk_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg;
    logic        bclk, lrclk, ovr;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    audio_clk_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_i          (cfg),
        .bclk_o         (bclk),
        .lrclk_o        (lrclk),
        .cfg_override_o (ovr)
    );

    // run 31, override 29, polarity 19, frame code 18:17, bit ratio 16
    localparam int NV = 7;
    localparam logic [31:0] VCFG [NV] = '{
        32'h8000_0000, 32'h8001_0000, 32'h800A_0000, 32'h800D_0000,
        32'hA004_0000, 32'h8007_0000, 32'h8003_0000 };
    localparam int VN [NV] = '{2, 4, 2, 4, 2, 4, 4};
    localparam int VF [NV] = '{32, 32, 64, 128, 128, 0, 64};
    localparam int VP [NV] = '{0, 0, 1, 1, 0, 0, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg   = 32'hA000_0000;
        repeat (4) step();
        // R9: reset holds outputs low even with run and override set
        chk(bclk == 1'b0, "R9 bclk in reset", int'(bclk), 0);
        chk(lrclk == 1'b0, "R9 lrclk in reset", int'(lrclk), 0);
        chk(ovr == 1'b0, "R9 override in reset", int'(ovr), 0);
        cfg   = 32'h0;
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int n, f, p, lim, first_exp;
            int prev_b, prev_l, last_b, last_l, nb, nl, bad_b, bad_lr, bad_edge, lr_hi, first_b;
            n = VN[v]; f = VF[v]; p = VP[v];
            cfg = 32'h0;
            repeat (3) step();
            // R6
            chk(bclk == 1'b0 && lrclk == 1'b0, "R6 outputs low while stopped",
                int'({bclk, lrclk}), 0);
            cfg = VCFG[v];
            lim = (f > 0) ? (n * f * 2 + 20) : 300;
            first_exp = (p == 0) ? (n / 2 + (f / 2 - 1) * n) : (f / 2 * n);
            prev_b = 0; prev_l = 0; last_b = 0; last_l = 0; nb = 0; nl = 0;
            bad_b = 0; bad_lr = 0; bad_edge = 0; lr_hi = 0; first_b = -1;
            for (int c = 1; c <= lim; c++) begin
                int b, l;
                step();
                b = int'(bclk);
                l = int'(lrclk);
                if (b != prev_b) begin
                    if (c - last_b != n / 2) bad_b++;
                    if (nb == 0) first_b = c;
                    nb++;
                    last_b = c;
                end
                if (l != prev_l) begin
                    if (nl == 0) begin
                        if (c != first_exp) bad_lr++;
                    end else if (c - last_l != f / 2 * n) begin
                        bad_lr++;
                    end
                    if (p == 0 && !(b == 1 && prev_b == 0)) bad_edge++;
                    if (p == 1 && !(b == 0 && prev_b == 1)) bad_edge++;
                    nl++;
                    last_l = c;
                end
                if (l == 1) lr_hi++;
                prev_b = b;
                prev_l = l;
            end
            // R1
            chk(bad_b == 0 && nb > 4, "R1 bit clock phase length", bad_b, 0);
            // R7
            chk(first_b == n / 2, "R7 first bit clock rise", first_b, n / 2);
            // R8
            chk(ovr == VCFG[v][29], "R8 override flag", int'(ovr), int'(VCFG[v][29]));
            if (f == 0) begin
                // R3
                chk(nl == 0 && lr_hi == 0, "R3 invalid frame code keeps lrclk low", lr_hi, 0);
            end else begin
                // R2 and R4: every phase is F/2 bit periods
                chk(bad_lr == 0 && nl >= 3, "R2 R4 frame phase length", bad_lr, 0);
                // R7
                chk(nl > 0 && (last_l - (nl - 1) * (f / 2 * n)) == first_exp,
                    "R7 first frame clock rise", last_l - (nl - 1) * (f / 2 * n), first_exp);
                // R5
                chk(bad_edge == 0, "R5 frame change on selected bit clock edge", bad_edge, 0);
            end
        end

        // R6: stopping mid-frame clears both outputs after one edge
        cfg = VCFG[0];
        repeat (40) step();
        cfg = 32'h0;
        step();
        chk(bclk == 1'b0 && lrclk == 1'b0, "R6 stop in mid-frame", int'({bclk, lrclk}), 0);

        // R8: override with run clear; R6 clocks stay low
        cfg = 32'h2000_0000;
        step();
        chk(ovr == 1'b1, "R8 override without run", int'(ovr), 1);
        chk(bclk == 1'b0 && lrclk == 1'b0, "R6 no clocks with run clear", int'({bclk, lrclk}), 0);

        // R9: asynchronous reset while running
        cfg = VCFG[4];
        repeat (70) step();
        rst_n = 1'b0;
        #1;
        chk(bclk == 1'b0 && lrclk == 1'b0 && ovr == 1'b0, "R9 reset while running",
            int'({bclk, lrclk, ovr}), 0);
        repeat (2) step();
        rst_n = 1'b1;
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule